// File: doc/BRIEF.md
# Region Integrity Descriptor Walker

The block steps through a chain of region descriptors stored in memory. A descriptor is four 32-bit words on a 16-byte grid. The words, in ascending address order, are the start address of the region, a configuration word, the address of the region's digest slot, and a follow-on field. For each descriptor the walker first reads the four words over a simple request/acknowledge memory port. It then starts an external hash engine with a one-cycle pulse. An internal counter model stands in for the engine's latency. When that latency has run out, the walker captures the digest bus. It then either stores the digest into the digest slot or reads the slot back and compares it word by word.

Several events are recorded in sticky per-region flags: a descriptor loaded, a chain end, a loop-back, a bus error, a digest mismatch, and a zero follow-on field. Inverted-sense disable bits in each configuration word keep the matching flags from setting. The interrupt line is the OR of every flag. Software writes ones to `flag_clr` to clear flags.

The controller state machine has six states. `S_IDLE` waits for `start_walk` and then goes to `S_FETCH`. `S_FETCH` reads the four descriptor words; after the fourth it goes to `S_HSTART`, and a bus error sends it to `S_IDLE`. `S_HSTART` issues the start pulse and goes to `S_HWAIT`. `S_HWAIT` waits for the latency model's done and then goes to `S_DIGEST`. `S_DIGEST` writes or compares the digest words; after the last word it goes to `S_FLAGS`, and a bus error sends it to `S_IDLE`. `S_FLAGS` records the end-of-descriptor flags. It then goes to `S_IDLE` when the end bit is set, and to `S_FETCH` at the next address otherwise.

Top module: `integrity_walker`

## Requirements
- R1: After reset, `flags` is all zero and `irq`, `busy`, `mem_req` and `hash_start` are low.
- R2: A `start_walk` pulse while idle captures `list_base` and begins reading the descriptor there. The reads go to byte offsets +0, +4, +8 and +12. Word 0 is the region address, word 1 the configuration, word 2 the digest-slot address and word 3 the follow-on field. A `start_walk` pulse while busy has no effect.
- R3: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ack` is high.
- R4: Next descriptor selection:
  - When the end bit (config bit 2) is 1, the walk stops and returns to idle after this descriptor, whatever the loop-back bit (bit 1) holds.
  - When the end bit is 0 and the loop-back bit is 0, the next descriptor is at the current address + 0x10.
  - When the end bit is 0 and the loop-back bit is 1, the next descriptor is at the value `list_base` has in that cycle, and that value becomes the new base.
- R5: The start pulse and its timing:
  - `hash_start` is a one-cycle pulse once a descriptor is loaded.
  - `hash_region` carries word 0.
  - `hash_sha256` is high exactly when config bits 14:12 equal 1.
  - The first digest-slot access is requested exactly L+1 cycles after the `hash_start` cycle. L is 80 when `hash_sha256` is low. When it is high, L is 72 if config bit 10 is 0 and 194 if bit 10 is 1.
- R6: With config bit 0 = 0, digest word i (`hash_digest[32i+31:32i]`) is written to slot address + 4i. Five words are written when `hash_sha256` is low and eight when it is high.
- R7: With config bit 0 = 1, the same words are read back. If any read word differs from the captured digest word, the mismatch condition is raised.
- R8: Flag layout and set conditions:
  - Flag kind k of region r is `flags[4k+r]`. The region r is ((descriptor address − base) >> 4) mod 4.
  - Kind 0 (descriptor loaded) sets after the fourth word is read.
  - Kind 1 (chain end) sets when the end bit is 1.
  - Kind 2 (loop-back) sets when the loop-back bit is 1 and the end bit is 0.
  - Kind 3 is the bus error.
  - Kind 4 (digest mismatch) sets on a compare mismatch.
  - Kind 5 (follow-on zero) sets when word 3 is zero.
- R9: Each flag kind has a disable bit in the configuration word: kind 0 → bit 9, 1 → bit 8, 2 → bit 7, 3 → bit 6, 4 → bit 5, 5 → bit 4. A disable bit of 1 keeps that flag from setting, and a 0 lets it set.
- R10: An acknowledged access with `mem_err` high does three things:
  - It sets the bus-error flag. The disable bit applies only once the configuration word of the current descriptor has been read; before that the flag always sets.
  - It ends the walk.
  - No further memory request follows.
- R11: Flags are sticky until a 1 is written at the same position of `flag_clr`. `irq` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_walk | input | 1 | Pulse that starts a walk when idle |
| list_base | input | 32 | Chain base address, also the loop-back target |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access had a bus error |
| hash_start | output | 1 | One-cycle hash start pulse |
| hash_region | output | 32 | Region start address for the hash engine |
| hash_sha256 | output | 1 | Long-digest algorithm selected |
| hash_digest | input | 256 | Digest from the hash engine |
| flag_clr | input | 24 | Write-one-to-clear flag mask |
| flags | output | 24 | Sticky per-region flags |
| irq | output | 1 | OR of all flags |
| busy | output | 1 | Walk in progress |

## Verification
Random chains vary the disable bits, the algorithm field, the delay bit and the compare/write mode. They also add noise in the unused configuration bits and stall the memory acknowledge at random. A design that indexed flags by chain position instead of by address offset, or that ignored a disable bit, would end with a flag vector that differs from the bench model.

Directed chains cover several corner cases:
- A loop-back taken to a new base, with a stray start pulse during the walk. Walking on past the loop-back, or restarting on the stray pulse, would shift the flag positions.
- End and loop-back set together. A design that honoured the loop-back there would set flag kind 2 and keep fetching.
- Bus errors both before and after the configuration word arrives. A design that gated the bus-error flag with a stale configuration, or that kept fetching after the error, shows up in the final flags and the request line.
- An off-by-one in the latency model, which shows up in the measured gap between `hash_start` and the first digest-slot request.

// File: rtl/iw_pkg.sv
package iw_pkg;

    // Flag kinds, one group of region bits each
    localparam int K_UPD  = 0;
    localparam int K_END  = 1;
    localparam int K_WRAP = 2;
    localparam int K_BUS  = 3;
    localparam int K_MIS  = 4;
    localparam int K_HC   = 5;
    localparam int NKIND  = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_HSTART,
        S_HWAIT,
        S_DIGEST,
        S_FLAGS
    } walk_state_t;

    typedef struct packed {
        logic             sha256;
        logic             slow;
        logic [NKIND-1:0] dis;
        logic             eom;
        logic             wrap;
        logic             cmp;
    } cfg_t;

    // Disable bit for kind k lives at configuration bit 9-k
    function automatic cfg_t decode_cfg(input logic [14:0] w);
        cfg_t c;
        c.sha256 = (w[14:12] == 3'd1);
        c.slow   = w[10];
        for (int k = 0; k < NKIND; k++) begin
            c.dis[k] = w[9-k];
        end
        c.eom  = w[2];
        c.wrap = w[1];
        c.cmp  = w[0];
        return c;
    endfunction

endpackage

// File: rtl/iw_hash_stub.sv
module iw_hash_stub #(
    parameter int LAT_SHA1 = 80,
    parameter int LAT_FAST = 72,
    parameter int LAT_SLOW = 194
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sha256,
    input  logic slow,
    output logic done
);
    localparam int LMAX_A = (LAT_FAST > LAT_SLOW) ? LAT_FAST : LAT_SLOW;
    localparam int LMAX   = (LAT_SHA1 > LMAX_A) ? LAT_SHA1 : LMAX_A;
    localparam int CW     = $clog2(LMAX + 1);

    logic [CW-1:0] cnt;
    logic          run;
    int            lat;

    always_comb begin
        if (sha256) lat = slow ? LAT_SLOW : LAT_FAST;
        else        lat = LAT_SHA1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(lat - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    start_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

// File: rtl/iw_flag_bank.sv
module iw_flag_bank #(
    parameter int NREG  = 4,
    parameter int NKIND = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NKIND*NREG-1:0] set_vec,
    input  logic [NKIND*NREG-1:0] clr_vec,
    output logic [NKIND*NREG-1:0] flags,
    output logic                  irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    assign irq = |flags;

    // R11
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(clr_vec)) & ~flags) == '0);

    // R11
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);

endmodule

// File: rtl/integrity_walker.sv
module integrity_walker
    import iw_pkg::*;
#(
    parameter int NREG       = 4,
    parameter int AW         = 32,
    parameter int DGW        = 256,
    parameter int SHA1_WORDS = 5,
    parameter int LAT_SHA1   = 80,
    parameter int LAT_FAST   = 72,
    parameter int LAT_SLOW   = 194
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_walk,
    input  logic [AW-1:0]         list_base,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    input  logic                  mem_ack,
    input  logic                  mem_err,
    output logic                  hash_start,
    output logic [AW-1:0]         hash_region,
    output logic                  hash_sha256,
    input  logic [DGW-1:0]        hash_digest,
    input  logic [NKIND*NREG-1:0] flag_clr,
    output logic [NKIND*NREG-1:0] flags,
    output logic                  irq,
    output logic                  busy
);
    localparam int WPD = DGW / 32;
    localparam int IW  = $clog2(WPD);
    localparam int RB  = $clog2(NREG);
    localparam int FW  = NKIND * NREG;
    localparam int DSC_STEP = 16;

    walk_state_t         st, st_nxt;
    logic [AW-1:0]       dsc, base_q, region_q, area_q;
    cfg_t                cfg;
    logic                nxt_zero, mism, h_done;
    logic [IW-1:0]       widx, lastw;
    logic [DGW-1:0]      dig;
    logic [31:0]         cur_word;
    logic [RB-1:0]       rgn;
    logic [NKIND-1:0]    kset;
    logic [FW-1:0]       set_vec;
    logic [AW-1:0]       woff;

    assign lastw    = cfg.sha256 ? IW'(WPD - 1) : IW'(SHA1_WORDS - 1);
    assign cur_word = dig[32*widx +: 32];
    assign woff     = {{(AW-IW-2){1'b0}}, widx, 2'b00};
    assign rgn      = RB'((dsc - base_q) >> 4);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:   if (start_walk) st_nxt = S_FETCH;
            S_FETCH:  if (mem_ack) begin
                          if (mem_err)                st_nxt = S_IDLE;
                          else if (widx == IW'(3))    st_nxt = S_HSTART;
                      end
            S_HSTART: st_nxt = S_HWAIT;
            S_HWAIT:  if (h_done) st_nxt = S_DIGEST;
            S_DIGEST: if (mem_ack) begin
                          if (mem_err)                st_nxt = S_IDLE;
                          else if (widx == lastw)     st_nxt = S_FLAGS;
                      end
            S_FLAGS:  st_nxt = cfg.eom ? S_IDLE : S_FETCH;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsc      <= '0;
            base_q   <= '0;
            region_q <= '0;
            area_q   <= '0;
            cfg      <= '0;
            nxt_zero <= 1'b0;
            mism     <= 1'b0;
            widx     <= '0;
            dig      <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start_walk) begin
                    dsc    <= list_base;
                    base_q <= list_base;
                    cfg    <= '0;
                    widx   <= '0;
                end
                S_FETCH: if (mem_ack && !mem_err) begin
                    widx <= (widx == IW'(3)) ? '0 : widx + 1'b1;
                    unique case (widx)
                        IW'(0):  region_q <= mem_rdata[AW-1:0];
                        IW'(1):  cfg      <= decode_cfg(mem_rdata[14:0]);
                        IW'(2):  area_q   <= mem_rdata[AW-1:0];
                        default: nxt_zero <= (mem_rdata == 32'd0);
                    endcase
                end
                S_HWAIT: if (h_done) begin
                    dig  <= hash_digest;
                    mism <= 1'b0;
                end
                S_DIGEST: if (mem_ack && !mem_err) begin
                    widx <= widx + 1'b1;
                    if (cfg.cmp && (mem_rdata != cur_word)) mism <= 1'b1;
                end
                S_FLAGS: if (!cfg.eom) begin
                    if (cfg.wrap) begin
                        dsc    <= list_base;
                        base_q <= list_base;
                    end else begin
                        dsc <= dsc + AW'(DSC_STEP);
                    end
                    cfg  <= '0;
                    widx <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        hash_start  = 1'b0;
        busy        = (st != S_IDLE);
        hash_region = region_q;
        hash_sha256 = cfg.sha256;
        unique case (st)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dsc + woff;
            end
            S_HSTART: hash_start = 1'b1;
            S_DIGEST: begin
                mem_req   = 1'b1;
                mem_we    = !cfg.cmp;
                mem_addr  = area_q + woff;
                mem_wdata = cfg.cmp ? 32'd0 : cur_word;
            end
            default: ;
        endcase
    end

    // Flag set requests
    always_comb begin
        kset = '0;
        unique case (st)
            S_FETCH: if (mem_ack) begin
                if (mem_err)               kset[K_BUS] = ~cfg.dis[K_BUS];
                else if (widx == IW'(3))   kset[K_UPD] = ~cfg.dis[K_UPD];
            end
            S_DIGEST: if (mem_ack && mem_err) kset[K_BUS] = ~cfg.dis[K_BUS];
            S_FLAGS: begin
                kset[K_END]  = cfg.eom & ~cfg.dis[K_END];
                kset[K_WRAP] = ~cfg.eom & cfg.wrap & ~cfg.dis[K_WRAP];
                kset[K_HC]   = nxt_zero & ~cfg.dis[K_HC];
                kset[K_MIS]  = mism & ~cfg.dis[K_MIS];
            end
            default: ;
        endcase
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_set
        assign set_vec[k*NREG +: NREG] = kset[k] ? (NREG'(1) << rgn) : '0;
    end

    iw_hash_stub #(
        .LAT_SHA1 (LAT_SHA1),
        .LAT_FAST (LAT_FAST),
        .LAT_SLOW (LAT_SLOW)
    ) i_stub (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hash_start),
        .sha256 (cfg.sha256),
        .slow   (cfg.slow),
        .done   (h_done)
    );

    iw_flag_bank #(
        .NREG  (NREG),
        .NKIND (NKIND)
    ) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (flag_clr),
        .flags   (flags),
        .irq     (irq)
    );

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);

    // R4
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mem_ack && mem_err) || $past(st == S_FLAGS && cfg.eom)));

    // R10
    err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> !mem_req);

endmodule

// File: tb/test_integrity_walker.sv
module test_integrity_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int FW   = 24;
    localparam logic [31:0] NO_ERR = 32'hFFFF_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_walk = 1'b0;
    logic [31:0]   list_base = '0;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr, mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0, mem_err = 1'b0;
    logic          hash_start, hash_sha256;
    logic [31:0]   hash_region;
    logic [255:0]  dig = '0;
    logic [FW-1:0] flag_clr = '0;
    logic [FW-1:0] flags;
    logic          irq, busy;

    integrity_walker i_integrity_walker (
        .clk(clk), .rst_n(rst_n), .start_walk(start_walk), .list_base(list_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .hash_start(hash_start), .hash_region(hash_region), .hash_sha256(hash_sha256),
        .hash_digest(dig), .flag_clr(flag_clr), .flags(flags), .irq(irq), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [256];
    logic [31:0] mm  [256];
    logic [31:0] err_addr = NO_ERR;
    int errors = 0, checks = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder and monitors, all at the falling edge
    logic        wr_pend = 0, rq_pend = 0, lat_pend = 0;
    logic [31:0] wa, wd, rq_addr;
    int          t0, lat_exp;
    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(0, "WATCHDOG", "run hung", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (mem_ack && wr_pend) mem[wa[9:2]] = wd;
        wr_pend = 0;
        if (rq_pend) chk(mem_req && mem_addr == rq_addr, "R3", "request held", mem_addr, rq_addr);
        if (lat_pend && mem_req) begin
            chk(cyc - t0 == lat_exp + 1, "R5", "digest access delay", cyc - t0, lat_exp + 1);
            lat_pend = 0;
        end
        if (hash_start) begin
            logic [31:0] c;
            c = mem[((hash_region - 32'h1000) >> 2) + 1];
            chk(hash_region[31:12] == 20'h1, "R5", "region address", hash_region, 32'h1000);
            chk(hash_sha256 == (c[14:12] == 3'd1), "R5", "algorithm", hash_sha256, c[14:12] == 3'd1);
            lat_exp = (c[14:12] == 3'd1) ? (c[10] ? 194 : 72) : 80;
            t0 = cyc;
            lat_pend = 1;
        end
        mem_ack = 0;
        mem_err = 0;
        rq_pend = 0;
        if (mem_req) begin
            if ($urandom % 4 != 0) begin
                mem_ack   = 1;
                mem_err   = (mem_addr == err_addr);
                mem_rdata = mem[mem_addr[9:2]];
                wr_pend   = mem_we && !mem_err;
                wa = mem_addr;
                wd = mem_wdata;
            end else begin
                rq_pend = 1;
                rq_addr = mem_addr;
            end
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] c,
                            input logic [31:0] area, input logic [31:0] nx);
        mem[a[9:2]]     = 32'h1000 + a;
        mem[a[9:2] + 1] = c;
        mem[a[9:2] + 2] = area;
        mem[a[9:2] + 3] = nx;
    endtask

    // Reference walk over a copy of memory (R4 R6 R7 R8 R9 R10)
    task automatic predict(input logic [31:0] b0, input logic [31:0] blive, output logic [FW-1:0] ex);
        logic [31:0] a, bl, aa;
        logic [31:0] w [4];
        logic [31:0] c;
        bit mis, stop;
        int r, n;
        for (int i = 0; i < 256; i++) mm[i] = mem[i];
        ex = '0; a = b0; bl = b0; stop = 0;
        for (int g = 0; g < 32 && !stop; g++) begin
            r = int'(((a - bl) >> 4) & 32'd3);
            c = '0;
            for (int k = 0; k < 4 && !stop; k++) begin
                if (a + 4*k == err_addr) begin
                    if (!c[6]) ex[12 + r] = 1'b1;
                    stop = 1;
                end else begin
                    w[k] = mm[(a + 4*k) >> 2 & 32'hFF];
                    if (k == 1) c = w[1];
                end
            end
            if (!stop) begin
                if (!c[9]) ex[0 + r] = 1'b1;
                n = (c[14:12] == 3'd1) ? 8 : 5;
                mis = 0;
                for (int i = 0; i < n && !stop; i++) begin
                    aa = w[2] + 4*i;
                    if (aa == err_addr) begin
                        if (!c[6]) ex[12 + r] = 1'b1;
                        stop = 1;
                    end else if (c[0]) begin
                        if (mm[aa[9:2]] != dig[32*i +: 32]) mis = 1;
                    end else begin
                        mm[aa[9:2]] = dig[32*i +: 32];
                    end
                end
                if (!stop) begin
                    if (c[2] && !c[8])              ex[4 + r]  = 1'b1;
                    if (!c[2] && c[1] && !c[7])     ex[8 + r]  = 1'b1;
                    if (mis && !c[5])               ex[16 + r] = 1'b1;
                    if (w[3] == 0 && !c[4])         ex[20 + r] = 1'b1;
                    if (c[2])       stop = 1;
                    else if (c[1])  begin a = blive; bl = blive; end
                    else            a = a + 16;
                end
            end
        end
    endtask

    task automatic run(input logic [31:0] b0, input logic [31:0] blive, input bit poke, input string tag);
        logic [FW-1:0] ex, mask;
        int n, bad;
        predict(b0, blive, ex);
        list_base = b0;
        start_walk = 1;
        @(negedge clk);
        start_walk = 0;
        list_base = blive;
        chk(busy, "R2", {tag, " walk started"}, busy, 1);
        n = 0;
        while (busy && n < 20000) begin
            if (poke && n == 30) start_walk = 1;
            @(negedge clk);
            start_walk = 0;
            n++;
        end
        chk(!busy, "R4", {tag, " walk ended"}, busy, 0);
        chk(!mem_req, "R10", {tag, " no request after end"}, mem_req, 0);
        chk(flags == ex, "R8 R9", {tag, " flags"}, flags, ex);
        chk(irq == (ex != 0), "R11", {tag, " irq"}, irq, ex != 0);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) bad++;
        chk(bad == 0, "R6 R7", {tag, " memory image"}, bad, 0);
        mask = FW'($urandom);
        flag_clr = mask;
        @(negedge clk);
        flag_clr = '0;
        chk(flags == (ex & ~mask), "R11", {tag, " partial clear"}, flags, ex & ~mask);
        flag_clr = '1;
        @(negedge clk);
        flag_clr = '0;
        chk(flags == 0 && !irq, "R11", {tag, " full clear"}, flags, 0);
    endtask

    task automatic fill();
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int i = 0; i < 8; i++) dig[32*i +: 32] = $urandom;
        err_addr = NO_ERR;
    endtask

    task automatic rand_scn();
        int n;
        logic [31:0] c, area;
        fill();
        n = 1 + $urandom % 4;
        for (int i = 0; i < n; i++) begin
            c = $urandom;
            c[0] = $urandom % 2;
            c[1] = (i == n - 1) ? 1'($urandom % 2) : 1'b0;
            c[2] = (i == n - 1);
            for (int k = 4; k <= 9; k++) c[k] = ($urandom % 4 == 0);
            c[10] = $urandom % 2;
            case ($urandom % 4)
                0: c[14:12] = 3'd0;
                3: c[14:12] = 3'd2;
                default: c[14:12] = 3'd1;
            endcase
            area = 32'h100 + 32'h20 * i;
            for (int j = 0; j < 8; j++)
                if (c[0] && ($urandom % 2 == 0)) mem[area[9:2] + j] = dig[32*j +: 32];
            put_desc(16 * i, c, area, ($urandom % 2) ? 32'd0 : ($urandom | 32'd1));
        end
        if ($urandom % 5 == 0) err_addr = 32'h4 * ($urandom % (4 * n));
        run(0, 0, 0, "random");
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1
        chk(flags == 0 && !irq && !busy, "R1", "reset flags/irq/busy", {flags, irq, busy}, 0);
        chk(!mem_req && !hash_start, "R1", "reset request/start", {mem_req, hash_start}, 0);
        rst_n = 1;
        @(negedge clk);

        // Loop-back to a new base, with a stray start pulse mid-walk (R2 R4)
        fill();
        put_desc(32'h00, 32'h0000_1000, 32'h100, 32'd5);
        put_desc(32'h10, 32'h0000_0002, 32'h120, 32'd0);
        put_desc(32'h40, 32'h0000_1405, 32'h140, 32'd0);
        run(32'h0, 32'h40, 1, "loop-back");

        // End and loop-back together: loop-back ignored (R4)
        fill();
        put_desc(32'h00, 32'h0000_0007, 32'h100, 32'd0);
        run(32'h0, 32'h0, 0, "end+loop");

        // Bus error on a fetch after the config word (R10)
        fill();
        put_desc(32'h00, 32'h0000_0000, 32'h100, 32'd1);
        put_desc(32'h10, 32'h0000_1004, 32'h120, 32'd1);
        err_addr = 32'h18;
        run(32'h0, 32'h0, 0, "fetch error");

        // Bus error on the region word, before config is read (R10)
        fill();
        put_desc(32'h00, 32'h0000_03F4, 32'h100, 32'd1);
        err_addr = 32'h0;
        run(32'h0, 32'h0, 0, "early error");

        // Bus error during the digest phase with its flag disabled (R9 R10)
        fill();
        put_desc(32'h00, 32'h0000_0044, 32'h100, 32'd1);
        err_addr = 32'h108;
        run(32'h0, 32'h0, 0, "digest error masked");

        // Every flag disabled, mismatching compare, zero follow-on (R9)
        fill();
        put_desc(32'h00, 32'h0000_13F5, 32'h100, 32'd0);
        run(32'h0, 32'h0, 0, "all disabled");

        // Matching compare in long mode: no mismatch flag (R7)
        fill();
        for (int j = 0; j < 8; j++) mem[64 + j] = dig[32*j +: 32];
        put_desc(32'h00, 32'h0000_1005, 32'h100, 32'd3);
        run(32'h0, 32'h0, 0, "match");

        for (int s = 0; s < 25; s++) rand_scn();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule